// File: doc/BRIEF.md
# MESI Per-Line Snooping Coherence Controller

This block keeps the coherence state of one line of a write-back cache that sits on a shared snooping bus. It takes read and write requests from its processor, decides whether the access can finish locally, and when it cannot, raises a bus request carrying one of four commands: read for sharing, read for ownership, invalidate, or write-back. Once the arbiter grants the bus, the command completes in that grant cycle. On a sharing read, the block samples the wired shared signal from the other caches to choose between a private clean fill and a shared fill.

The same block watches the commands that other caches put on the bus. When a snooped address matches the held line, it drives its own shared response combinationally in the snoop cycle. It pulses a write-back strobe when the line is dirty and another cache wants it, and it demotes or invalidates the line. A snoop can also rewrite a pending request. An upgrade that loses its copy becomes a read for ownership, and a pending eviction write-back is dropped when a snoop has already flushed the dirty line.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset, and after any later reset, `line_state` is Invalid (0), `bus_req` is low and `cpu_done` is low.
- R2: A read miss with `bus_shared_in` low at the grant issues the read command (`bus_op` 0) at the request address and fills the line as Exclusive (2).
- R3: A read miss with `bus_shared_in` high at the grant fills the line as Shared (1).
- R4: A write miss issues the read-for-ownership command (`bus_op` 1) and fills the line as Modified (3).
- R5: A read hit on any valid line, and a write hit on a Modified or Exclusive line, finish in the request cycle with no bus request. A write hit on Exclusive moves the line to Modified.
- R6: A write hit on a Shared line issues the invalidate command (`bus_op` 2) and ends Modified after the grant.
- R7: A miss that replaces a Modified line first issues the write-back command (`bus_op` 3) with the old line address, then the read or read-for-ownership fill.
- R8: A snooped read that hits a valid line raises `snp_shared_out` in that cycle. Modified and Exclusive lines become Shared, and a Modified line also pulses `snp_wb`.
- R9: A snooped read-for-ownership that hits a valid line makes it Invalid, and pulses `snp_wb` if the line was Modified.
- R10: A snooped invalidate that hits a valid line makes it Invalid without a write-back.
- R11: A snoop to another address, a snoop to an Invalid line, and a snooped write-back leave the state unchanged, with no shared response and no strobe.
- R12: A pending invalidate whose line is invalidated by a snooped read-for-ownership or invalidate is turned into a read-for-ownership request, and the write still ends Modified.
- R13: A pending eviction write-back is dropped when a snoop leaves the line no longer Modified, and the request goes straight to the fill.
- R14: `bus_req` stays high with a stable command until `bus_grant`, and a bus-served request signals `cpu_done` in its grant cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present, held until `cpu_done` |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Line address of the request |
| cpu_done | output | 1 | Request completes this cycle |
| bus_req | output | 1 | Bus command pending |
| bus_op | output | 2 | 0 read, 1 read for ownership, 2 invalidate, 3 write-back |
| bus_addr | output | ADDR_W | Address of the pending command |
| bus_grant | input | 1 | Arbiter grant, command completes this cycle |
| bus_shared_in | input | 1 | Wired shared line from the other caches |
| snp_valid | input | 1 | Another cache's command is on the bus |
| snp_op | input | 2 | Snooped command, same coding as `bus_op` |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_shared_out | output | 1 | This cache holds the snooped line |
| snp_wb | output | 1 | Dirty data must be flushed for the snoop |
| line_state | output | 2 | 0 Invalid, 1 Shared, 2 Exclusive, 3 Modified |

## Verification
The checks assume that the arbiter never grants this cache in a cycle that carries another cache's snoop. They also assume that the processor holds its address and direction steady from the request until `cpu_done`. The stimulus raises `bus_grant` only in cycles with no snoop and changes the request only after completion. It places snoops while a request waits ungranted, which is how the upgrade-cancel and dropped-write-back cases are reached. Those assumptions are themselves checked, so a stimulus slip shows up as a failure rather than as a misleading pass.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        OP_RD  = 2'd0,
        OP_RDX = 2'd1,
        OP_INV = 2'd2,
        OP_WB  = 2'd3
    } bus_op_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_REQ  = 1'b1
    } phase_e;

    typedef struct packed {
        line_st_e st;
        logic     wb;
        logic     shared;
        logic     kill_upg;
    } snoop_resp_t;

    function automatic logic st_valid(input line_st_e s);
        return s != ST_I;
    endfunction

    function automatic bus_op_e fill_op(input logic is_write);
        return is_write ? OP_RDX : OP_RD;
    endfunction

endpackage

// File: rtl/mesi_tag_match.sv
module mesi_tag_match
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  line_st_e            st,
    input  logic [ADDR_W-1:0]   tag,
    input  logic [ADDR_W-1:0]   addr,
    output logic                hit
);
    assign hit = st_valid(st) && (tag == addr);
endmodule

// File: rtl/mesi_snoop_react.sv
module mesi_snoop_react
    import mesi_pkg::*;
(
    input  logic        valid,
    input  logic        hit,
    input  line_st_e    st,
    input  bus_op_e     op,
    output snoop_resp_t rsp
);
    always_comb begin
        rsp.st       = st;
        rsp.wb       = 1'b0;
        rsp.shared   = 1'b0;
        rsp.kill_upg = 1'b0;
        if (valid && hit) begin
            unique case (op)
                OP_RD: begin
                    rsp.shared = 1'b1;
                    rsp.wb     = (st == ST_M);
                    rsp.st     = ST_S;
                end
                OP_RDX: begin
                    rsp.wb       = (st == ST_M);
                    rsp.st       = ST_I;
                    rsp.kill_upg = 1'b1;
                end
                OP_INV: begin
                    rsp.st       = ST_I;
                    rsp.kill_upg = 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_done,
    output logic              bus_req,
    output logic [1:0]        bus_op,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_grant,
    input  logic              bus_shared_in,
    input  logic              snp_valid,
    input  logic [1:0]        snp_op,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared_out,
    output logic              snp_wb,
    output logic [1:0]        line_state
);
    line_st_e          st_q, st_d;
    logic [ADDR_W-1:0] tag_q, tag_d;
    phase_e            ph_q, ph_d;
    bus_op_e           op_q, op_d;
    bus_op_e           fin_q, fin_d;
    logic              cpu_hit, snp_hit;
    snoop_resp_t       srsp;

    mesi_tag_match #(.ADDR_W(ADDR_W)) u_cpu_match (
        .st(st_q), .tag(tag_q), .addr(cpu_addr), .hit(cpu_hit)
    );

    mesi_tag_match #(.ADDR_W(ADDR_W)) u_snp_match (
        .st(st_q), .tag(tag_q), .addr(snp_addr), .hit(snp_hit)
    );

    mesi_snoop_react u_react (
        .valid(snp_valid), .hit(snp_hit), .st(st_q),
        .op(bus_op_e'(snp_op)), .rsp(srsp)
    );

    assign bus_req        = (ph_q == PH_REQ);
    assign bus_op         = op_q;
    assign bus_addr       = (op_q == OP_WB) ? tag_q : cpu_addr;
    assign snp_shared_out = srsp.shared;
    assign snp_wb         = srsp.wb;
    assign line_state     = st_q;

    always_comb begin
        st_d     = st_q;
        tag_d    = tag_q;
        ph_d     = ph_q;
        op_d     = op_q;
        fin_d    = fin_q;
        cpu_done = 1'b0;
        if (snp_valid) begin
            st_d = srsp.st;
            if (ph_q == PH_REQ) begin
                if (op_q == OP_INV && srsp.kill_upg) begin
                    op_d  = OP_RDX;
                    fin_d = OP_RDX;
                end else if (op_q == OP_WB && srsp.st != ST_M) begin
                    op_d = fin_q;
                end
            end
        end else if (ph_q == PH_IDLE) begin
            if (cpu_valid) begin
                if (cpu_hit) begin
                    if (!cpu_write) begin
                        cpu_done = 1'b1;
                    end else if (st_q == ST_S) begin
                        ph_d  = PH_REQ;
                        op_d  = OP_INV;
                        fin_d = OP_INV;
                    end else begin
                        st_d     = ST_M;
                        cpu_done = 1'b1;
                    end
                end else begin
                    ph_d  = PH_REQ;
                    fin_d = fill_op(cpu_write);
                    op_d  = (st_q == ST_M) ? OP_WB : fill_op(cpu_write);
                end
            end
        end else if (bus_grant) begin
            unique case (op_q)
                OP_WB: begin
                    st_d = ST_I;
                    op_d = fin_q;
                end
                OP_RD: begin
                    st_d     = bus_shared_in ? ST_S : ST_E;
                    tag_d    = cpu_addr;
                    ph_d     = PH_IDLE;
                    cpu_done = 1'b1;
                end
                OP_RDX: begin
                    st_d     = ST_M;
                    tag_d    = cpu_addr;
                    ph_d     = PH_IDLE;
                    cpu_done = 1'b1;
                end
                OP_INV: begin
                    st_d     = ST_M;
                    ph_d     = PH_IDLE;
                    cpu_done = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_I;
            tag_q <= '0;
            ph_q  <= PH_IDLE;
            op_q  <= OP_RD;
            fin_q <= OP_RD;
        end else begin
            st_q  <= st_d;
            tag_q <= tag_d;
            ph_q  <= ph_d;
            op_q  <= op_d;
            fin_q <= fin_d;
        end
    end
endmodule

// File: rtl/mesi_line_chk.sv
module mesi_line_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_valid,
    input logic              cpu_write,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_done,
    input logic              bus_req,
    input logic [1:0]        bus_op,
    input logic              bus_grant,
    input logic              snp_valid,
    input logic              snp_shared_out,
    input logic              snp_wb,
    input logic [1:0]        line_state
);
    // R8
    shared_resp_chk: assert property (@(posedge clk) disable iff (rst)
        snp_shared_out |-> (snp_valid && line_state != 2'd0));

    // R9
    wb_from_dirty_chk: assert property (@(posedge clk) disable iff (rst)
        snp_wb |-> line_state == 2'd3);

    // R9
    wb_leaves_dirty_chk: assert property (@(posedge clk) disable iff (rst)
        snp_wb |=> line_state != 2'd3);

    // R14
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_grant && !snp_valid) |=> (bus_req && $stable(bus_op)));

    // R14
    grant_snoop_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_grant && snp_valid));

    // R14
    cpu_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && !cpu_done) |=> (cpu_valid && $stable(cpu_addr) && $stable(cpu_write)));

    // R6
    inv_from_shared_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_op == 2'd2) |-> line_state == 2'd1);

    // R7
    evict_from_dirty_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_op == 2'd3) |-> line_state == 2'd3);

    // R4
    write_ends_dirty_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_done && cpu_write) |=> line_state == 2'd3);

    // R5
    read_leaves_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_done && !cpu_write) |=> line_state != 2'd0);
endmodule

bind mesi_line_ctrl mesi_line_chk #(.ADDR_W(ADDR_W)) u_line_chk (
    .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
    .cpu_addr(cpu_addr), .cpu_done(cpu_done), .bus_req(bus_req),
    .bus_op(bus_op), .bus_grant(bus_grant), .snp_valid(snp_valid),
    .snp_shared_out(snp_shared_out), .snp_wb(snp_wb), .line_state(line_state)
);

// File: tb/test_mesi_line_ctrl.sv
module test_mesi_line_ctrl;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_valid = 1'b0, cpu_write = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic          cpu_done;
    logic          bus_req;
    logic [1:0]    bus_op;
    logic [AW-1:0] bus_addr;
    logic          bus_grant = 1'b0, bus_shared_in = 1'b0;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_op = 2'd0;
    logic [AW-1:0] snp_addr = '0;
    logic          snp_shared_out, snp_wb;
    logic [1:0]    line_state;

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    always #5 clk = ~clk;

    mesi_line_ctrl #(.ADDR_W(AW)) i_mesi_line_ctrl (
        .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
        .cpu_addr(cpu_addr), .cpu_done(cpu_done), .bus_req(bus_req),
        .bus_op(bus_op), .bus_addr(bus_addr), .bus_grant(bus_grant),
        .bus_shared_in(bus_shared_in), .snp_valid(snp_valid), .snp_op(snp_op),
        .snp_addr(snp_addr), .snp_shared_out(snp_shared_out), .snp_wb(snp_wb),
        .line_state(line_state)
    );

    typedef struct packed {
        logic       snp;
        logic [1:0] op;
        logic [7:0] addr;
        logic       sh;
        logic [1:0] st;
        logic [1:0] n;
        logic [1:0] op0;
        logic [1:0] op1;
        logic [7:0] a0;
        logic       esh;
        logic       ewb;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t TAB [NV] = '{
        '{1'b0, 2'd0, 8'h10, 1'b0, 2'd2, 2'd1, 2'd0, 2'd0, 8'h10, 1'b0, 1'b0, 4'd2},  // R2 read miss alone
        '{1'b0, 2'd1, 8'h10, 1'b0, 2'd3, 2'd0, 2'd0, 2'd0, 8'h00, 1'b0, 1'b0, 4'd5},  // R5 silent upgrade
        '{1'b0, 2'd0, 8'h10, 1'b0, 2'd3, 2'd0, 2'd0, 2'd0, 8'h00, 1'b0, 1'b0, 4'd5},  // R5 read hit on M
        '{1'b1, 2'd0, 8'h10, 1'b0, 2'd1, 2'd0, 2'd0, 2'd0, 8'h00, 1'b1, 1'b1, 4'd8},  // R8 M to S with flush
        '{1'b0, 2'd1, 8'h10, 1'b0, 2'd3, 2'd1, 2'd2, 2'd0, 8'h10, 1'b0, 1'b0, 4'd6},  // R6 upgrade from S
        '{1'b0, 2'd0, 8'h20, 1'b1, 2'd1, 2'd2, 2'd3, 2'd0, 8'h10, 1'b0, 1'b0, 4'd7},  // R7 evict then R3 fill
        '{1'b1, 2'd0, 8'h20, 1'b0, 2'd1, 2'd0, 2'd0, 2'd0, 8'h00, 1'b1, 1'b0, 4'd8},  // R8 S stays S
        '{1'b1, 2'd1, 8'h30, 1'b0, 2'd1, 2'd0, 2'd0, 2'd0, 8'h00, 1'b0, 1'b0, 4'd11}, // R11 other address
        '{1'b1, 2'd2, 8'h20, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 8'h00, 1'b0, 1'b0, 4'd10}, // R10 invalidate
        '{1'b1, 2'd0, 8'h20, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 8'h00, 1'b0, 1'b0, 4'd11}, // R11 invalid line
        '{1'b0, 2'd1, 8'h30, 1'b0, 2'd3, 2'd1, 2'd1, 2'd0, 8'h30, 1'b0, 1'b0, 4'd4},  // R4 write miss
        '{1'b1, 2'd1, 8'h30, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 8'h00, 1'b0, 1'b1, 4'd9},  // R9 steal dirty line
        '{1'b0, 2'd0, 8'h30, 1'b0, 2'd2, 2'd1, 2'd0, 2'd0, 8'h30, 1'b0, 1'b0, 4'd2},  // R2 refill private
        '{1'b1, 2'd0, 8'h30, 1'b0, 2'd1, 2'd0, 2'd0, 2'd0, 8'h00, 1'b1, 1'b0, 4'd8},  // R8 E to S
        '{1'b1, 2'd3, 8'h30, 1'b0, 2'd1, 2'd0, 2'd0, 2'd0, 8'h00, 1'b0, 1'b0, 4'd11}, // R11 snooped write-back
        '{1'b0, 2'd0, 8'h30, 1'b0, 2'd1, 2'd0, 2'd0, 2'd0, 8'h00, 1'b0, 1'b0, 4'd5}   // R5 read hit on S
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 state out of reset
        chk("R1", "state", line_state, 0);
        chk("R1", "bus_req", bus_req, 0);
        chk("R1", "cpu_done", cpu_done, 0);
        rst = 1'b0;

        for (int r = 0; r < NV; r++) begin
            string rq;
            rq = $sformatf("R%0d row%0d", TAB[r].req, r);
            if (TAB[r].snp) begin
                @(negedge clk);
                snp_valid = 1'b1; snp_op = TAB[r].op; snp_addr = TAB[r].addr;
                #1;
                chk(rq, "shared", snp_shared_out, TAB[r].esh);
                chk(rq, "wb", snp_wb, TAB[r].ewb);
                @(negedge clk);
                snp_valid = 1'b0;
                chk(rq, "state", line_state, TAB[r].st);
            end else begin
                int n;
                logic [1:0] ops [2];
                logic [7:0] a0;
                bit done;
                n = 0; done = 1'b0; a0 = '0;
                ops[0] = 2'd0; ops[1] = 2'd0;
                @(negedge clk);
                cpu_valid = 1'b1; cpu_write = TAB[r].op[0];
                cpu_addr = TAB[r].addr; bus_shared_in = TAB[r].sh;
                for (int k = 0; k < 6 && !done; k++) begin
                    #1;
                    if (bus_req) begin
                        if (n < 2) ops[n] = bus_op;
                        if (n == 0) a0 = bus_addr;
                        n++;
                        bus_grant = 1'b1;
                        #1;
                    end
                    done = cpu_done;
                    @(negedge clk);
                    bus_grant = 1'b0;
                end
                cpu_valid = 1'b0;
                chk(rq, "done", done, 1);
                chk(rq, "state", line_state, TAB[r].st);
                chk(rq, "bus_ops", n, TAB[r].n);
                if (TAB[r].n > 0) begin
                    chk(rq, "op0", ops[0], TAB[r].op0);
                    chk(rq, "addr0", a0, TAB[r].a0);
                end
                if (TAB[r].n > 1) chk(rq, "op1", ops[1], TAB[r].op1);
            end
        end

        // R12 upgrade cancelled by a snooped read-for-ownership. Line is S at 0x30.
        @(negedge clk);
        cpu_valid = 1'b1; cpu_write = 1'b1; cpu_addr = 8'h30;
        @(negedge clk);
        chk("R6", "inv pending", {bus_req, bus_op}, {1'b1, 2'd2});
        snp_valid = 1'b1; snp_op = 2'd1; snp_addr = 8'h30;
        #1;
        chk("R12", "no flush from S", snp_wb, 0);
        @(negedge clk);
        snp_valid = 1'b0;
        #1;
        chk("R12", "retried op", bus_op, 2'd1);
        chk("R12", "lost copy", line_state, 0);
        bus_grant = 1'b1;
        #1;
        chk("R14", "done at grant", cpu_done, 1);
        @(negedge clk);
        bus_grant = 1'b0; cpu_valid = 1'b0;
        chk("R12", "ends dirty", line_state, 3);

        // R13 eviction write-back dropped after a snoop flush. Line is M at 0x30.
        cpu_valid = 1'b1; cpu_write = 1'b0; cpu_addr = 8'h40; bus_shared_in = 1'b0;
        @(negedge clk);
        chk("R7", "evict op", {bus_req, bus_op}, {1'b1, 2'd3});
        chk("R7", "evict addr", bus_addr, 8'h30);
        @(negedge clk);
        chk("R14", "req held", {bus_req, bus_op}, {1'b1, 2'd3});
        snp_valid = 1'b1; snp_op = 2'd0; snp_addr = 8'h30;
        #1;
        chk("R8", "flush strobe", {snp_wb, snp_shared_out}, 2'b11);
        @(negedge clk);
        snp_valid = 1'b0;
        #1;
        chk("R13", "skip to fill", {bus_req, bus_op}, {1'b1, 2'd0});
        chk("R13", "demoted", line_state, 1);
        bus_grant = 1'b1;
        #1;
        chk("R13", "done", cpu_done, 1);
        @(negedge clk);
        bus_grant = 1'b0; cpu_valid = 1'b0;
        chk("R13", "filled private", line_state, 2);

        // R1 reset mid-run
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1", "state after reset", line_state, 0);
        chk("R1", "bus_req after reset", bus_req, 0);
        rst = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule